// File: doc/BRIEF.md
# Programmable Interval Timer Channel Bank

This block holds several identical down-timing channels of a classic interval timer. Each channel measures timer-clock ticks elapsed since its count was last loaded. It drives one output line whose waveform depends on the channel's operating mode. There are six behaviours: a terminal-count flag, a one-shot window, a rate pulse, a square wave, and two strobe variants. A loaded value of zero stands for the full range of 2^CW ticks. All channels share one tick enable, so time advances only on cycles where `tick_en` is high.

Beside the output, each channel reports how many further ticks will pass before its output next changes, together with a flag that is low once the output can no longer change. A gate bit per channel is stored with per-channel reset defaults and can be written individually. The gate does not change the counting or the output. Higher layers use the prediction to schedule interrupts without polling the output on every tick.

Top module: `pit_timer`

## Requirements
- R1: After reset every channel is in square-wave mode (code 3) with an effective count of 2^CW. The output is therefore high, the next-change delay is 2^(CW-1) with the valid flag set, and `gate_q` equals RST_GATES (channels 0 and 1 high, channel 2 low by default).
- R2: A loaded count of 0 is taken as 2^CW.
- R3: Mode 0, and the unused codes 6 and 7, keep the output low until the elapsed ticks reach the count, then hold it high.
- R4: Mode 1 holds the output high while the elapsed ticks are below the count and low from then on.
- R5: Mode 2 drives the output high for one tick whenever the elapsed ticks are a nonzero multiple of the count, and low otherwise. With a count of 1, the output stays high from the first tick on.
- R6: Mode 3 holds the output high for the first (count+1)/2 ticks of each period and low for the rest. A count of 1 gives a constant high.
- R7: Modes 4 and 5 drive the output high only on the tick where the elapsed ticks equal the count.
- R8: `nxt_delay` gives the number of ticks until the output next changes. When no change will ever occur, `nxt_valid` is low and `nxt_delay` reads 0.
- R9: A load restarts the elapsed tick count at zero. A tick in the same cycle as a load is discarded.
- R10: In modes 0, 1, 4 and 5 the elapsed count saturates, so the output never changes again after its final transition, however many ticks follow.
- R11: Loads and gate writes for one channel leave every other channel's state untouched. The gate is a per-channel stored bit read back on `gate_q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Timer tick qualifier shared by all channels |
| ld_en | input | NCH | Per-channel load strobe |
| ld_mode | input | 3*NCH | Mode code per channel (bits [3c+2:3c]) |
| ld_count | input | CW*NCH | Count per channel, 0 means 2^CW |
| gate_wr | input | NCH | Per-channel gate write strobe |
| gate_val | input | NCH | Gate value written when strobed |
| ch_out | output | NCH | Channel output lines |
| nxt_valid | output | NCH | A further output change is pending |
| nxt_delay | output | (CW+1)*NCH | Ticks until the next output change |
| gate_q | output | NCH | Stored gate bits |

## Verification
A load and a tick can land on the same clock edge. In that case the load must win and the tick must be lost rather than counted against the new value. The bench loads a channel with `tick_en` already high during the load cycle. It then reads the delay report before any further edge, expecting exactly the loaded count. It also checks that the next tick lowers the report by one.

// File: rtl/pit_pkg.sv
package pit_pkg;

  typedef enum logic [2:0] {
    MD_TERM    = 3'd0,
    MD_ONESHOT = 3'd1,
    MD_RATE    = 3'd2,
    MD_SQUARE  = 3'd3,
    MD_SWSTB   = 3'd4,
    MD_HWSTB   = 3'd5,
    MD_ALT6    = 3'd6,
    MD_ALT7    = 3'd7
  } mode_t;

  // Codes above 5 fold onto the terminal-count behaviour.
  function automatic mode_t fold_mode(input logic [2:0] m);
    if (m > 3'd5) return MD_TERM;
    return mode_t'(m);
  endfunction

  function automatic logic is_periodic(input mode_t m);
    return (m == MD_RATE) || (m == MD_SQUARE);
  endfunction

endpackage

// File: rtl/pit_phase.sv
module pit_phase
  import pit_pkg::*;
#(
  parameter int EW      = 18,
  parameter int RST_CNT = 65536
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          ld,
  input  mode_t         ld_mode,
  input  logic [EW-1:0] ld_cnt,
  output mode_t         mode_q,
  output logic [EW-1:0] cnt_q,
  output logic [EW-1:0] el_q,
  output logic          run_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MD_SQUARE;
      cnt_q  <= EW'(RST_CNT);
      el_q   <= '0;
      run_q  <= 1'b0;
    end else if (ld) begin
      mode_q <= ld_mode;
      cnt_q  <= ld_cnt;
      el_q   <= '0;
      run_q  <= 1'b0;
    end else if (tick) begin
      run_q <= 1'b1;
      if (is_periodic(mode_q)) begin
        el_q <= (el_q == cnt_q - EW'(1)) ? '0 : el_q + EW'(1);
      end else if (el_q <= cnt_q) begin
        el_q <= el_q + EW'(1);
      end
    end
  end

  AST_PERIODIC_RANGE: assert property (@(posedge clk) disable iff (rst)
    is_periodic(mode_q) |-> (el_q < cnt_q)); // R5

  AST_SAT_BOUND: assert property (@(posedge clk) disable iff (rst)
    !is_periodic(mode_q) |-> (el_q <= cnt_q + EW'(1))); // R10

  AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (rst)
    ld |=> (el_q == '0 && !run_q)); // R9

endmodule

// File: rtl/pit_decode.sv
module pit_decode
  import pit_pkg::*;
#(
  parameter int EW = 18,
  parameter int DW = 17
) (
  input  mode_t         mode,
  input  logic [EW-1:0] cnt,
  input  logic [EW-1:0] el,
  input  logic          run,
  output logic          o,
  output logic          nv,
  output logic [DW-1:0] nd
);

  logic [EW-1:0] half;
  logic [EW-1:0] rem;

  always_comb begin
    half = (cnt + EW'(1)) >> 1;
    o    = 1'b0;
    nv   = 1'b0;
    rem  = '0;
    case (mode)
      MD_RATE: begin
        o   = run && (el == '0);
        nv  = !((cnt == EW'(1)) && run);
        rem = o ? EW'(1) : cnt - el;
      end
      MD_SQUARE: begin
        o   = el < half;
        nv  = cnt != EW'(1);
        rem = o ? half - el : cnt - el;
      end
      MD_SWSTB, MD_HWSTB: begin
        o   = el == cnt;
        nv  = el <= cnt;
        rem = o ? EW'(1) : cnt - el;
      end
      MD_ONESHOT: begin
        o   = el < cnt;
        nv  = el < cnt;
        rem = cnt - el;
      end
      default: begin
        o   = el >= cnt;
        nv  = el < cnt;
        rem = cnt - el;
      end
    endcase
    nd = nv ? DW'(rem) : '0;
  end

endmodule

// File: rtl/pit_chan.sv
module pit_chan
  import pit_pkg::*;
#(
  parameter int   CW       = 16,
  parameter logic RST_GATE = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          ld,
  input  logic [2:0]    ld_mode,
  input  logic [CW-1:0] ld_val,
  input  logic          gate_wr,
  input  logic          gate_d,
  output logic          out,
  output logic          nv,
  output logic [CW:0]   nd,
  output logic          gate_q
);

  localparam int EW      = CW + 2;
  localparam int DW      = CW + 1;
  localparam int FULL    = 1 << CW;

  mode_t         mode_q;
  logic [EW-1:0] cnt_q, el_q, ld_cnt;
  logic          run_q;

  assign ld_cnt = (ld_val == '0) ? EW'(FULL) : EW'(ld_val);

  pit_phase #(.EW(EW), .RST_CNT(FULL)) u_phase (
    .clk(clk), .rst(rst), .tick(tick), .ld(ld),
    .ld_mode(fold_mode(ld_mode)), .ld_cnt(ld_cnt),
    .mode_q(mode_q), .cnt_q(cnt_q), .el_q(el_q), .run_q(run_q)
  );

  pit_decode #(.EW(EW), .DW(DW)) u_dec (
    .mode(mode_q), .cnt(cnt_q), .el(el_q), .run(run_q),
    .o(out), .nv(nv), .nd(nd)
  );

  always_ff @(posedge clk) begin
    if (rst)          gate_q <= RST_GATE;
    else if (gate_wr) gate_q <= gate_d;
  end

  AST_EDGE_PREDICTED: assert property (@(posedge clk) disable iff (rst)
    (nv && nd == DW'(1) && tick && !ld) |=> (out != $past(out))); // R8

  AST_QUIET_WHEN_DONE: assert property (@(posedge clk) disable iff (rst)
    (!nv && tick && !ld) |=> $stable(out)); // R10

  AST_GATE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !gate_wr |=> $stable(gate_q)); // R11

endmodule

// File: rtl/pit_timer.sv
module pit_timer #(
  parameter int             NCH       = 3,
  parameter int             CW        = 16,
  parameter logic [NCH-1:0] RST_GATES = NCH'(3'b011)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick_en,
  input  logic [NCH-1:0]      ld_en,
  input  logic [3*NCH-1:0]    ld_mode,
  input  logic [CW*NCH-1:0]   ld_count,
  input  logic [NCH-1:0]      gate_wr,
  input  logic [NCH-1:0]      gate_val,
  output logic [NCH-1:0]      ch_out,
  output logic [NCH-1:0]      nxt_valid,
  output logic [(CW+1)*NCH-1:0] nxt_delay,
  output logic [NCH-1:0]      gate_q
);

  localparam int DW = CW + 1;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    pit_chan #(.CW(CW), .RST_GATE(RST_GATES[c])) u_chan (
      .clk(clk), .rst(rst), .tick(tick_en), .ld(ld_en[c]),
      .ld_mode(ld_mode[3*c +: 3]), .ld_val(ld_count[CW*c +: CW]),
      .gate_wr(gate_wr[c]), .gate_d(gate_val[c]),
      .out(ch_out[c]), .nv(nxt_valid[c]), .nd(nxt_delay[DW*c +: DW]),
      .gate_q(gate_q[c])
    );
  end

endmodule

// File: tb/sim_pit_timer.sv
module sim_pit_timer;

  localparam int NCH = 3;
  localparam int CW  = 16;
  localparam int DW  = CW + 1;
  localparam int NV  = 23;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_en = 1'b0;
  logic [NCH-1:0]      ld_en = '0;
  logic [3*NCH-1:0]    ld_mode = '0;
  logic [CW*NCH-1:0]   ld_count = '0;
  logic [NCH-1:0]      gate_wr = '0;
  logic [NCH-1:0]      gate_val = '0;
  logic [NCH-1:0]      ch_out, nxt_valid, gate_q;
  logic [DW*NCH-1:0]   nxt_delay;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  pit_timer #(.NCH(NCH), .CW(CW)) u0 (
    .clk(clk), .rst(rst), .tick_en(tick_en), .ld_en(ld_en),
    .ld_mode(ld_mode), .ld_count(ld_count), .gate_wr(gate_wr),
    .gate_val(gate_val), .ch_out(ch_out), .nxt_valid(nxt_valid),
    .nxt_delay(nxt_delay), .gate_q(gate_q)
  );

  // {req, mode, count, ticks, out, valid, delay}
  localparam logic [49:0] VEC [0:NV-1] = '{
    {4'd3, 3'd0, 16'd5, 8'd0,  1'b0, 1'b1, 17'd5},   // R3
    {4'd3, 3'd0, 16'd5, 8'd4,  1'b0, 1'b1, 17'd1},   // R3
    {4'd3, 3'd0, 16'd5, 8'd5,  1'b1, 1'b0, 17'd0},   // R3
    {4'd3, 3'd6, 16'd2, 8'd2,  1'b1, 1'b0, 17'd0},   // R3
    {4'd3, 3'd7, 16'd2, 8'd1,  1'b0, 1'b1, 17'd1},   // R3
    {4'd10, 3'd0, 16'd5, 8'd20, 1'b1, 1'b0, 17'd0},  // R10
    {4'd10, 3'd5, 16'd3, 8'd9,  1'b0, 1'b0, 17'd0},  // R10
    {4'd4, 3'd1, 16'd4, 8'd0,  1'b1, 1'b1, 17'd4},   // R4
    {4'd8, 3'd1, 16'd4, 8'd4,  1'b0, 1'b0, 17'd0},   // R8
    {4'd5, 3'd2, 16'd3, 8'd0,  1'b0, 1'b1, 17'd3},   // R5
    {4'd5, 3'd2, 16'd3, 8'd3,  1'b1, 1'b1, 17'd1},   // R5
    {4'd5, 3'd2, 16'd3, 8'd4,  1'b0, 1'b1, 17'd2},   // R5
    {4'd5, 3'd2, 16'd1, 8'd0,  1'b0, 1'b1, 17'd1},   // R5
    {4'd5, 3'd2, 16'd1, 8'd2,  1'b1, 1'b0, 17'd0},   // R5
    {4'd6, 3'd3, 16'd5, 8'd0,  1'b1, 1'b1, 17'd3},   // R6
    {4'd6, 3'd3, 16'd5, 8'd3,  1'b0, 1'b1, 17'd2},   // R6
    {4'd6, 3'd3, 16'd5, 8'd5,  1'b1, 1'b1, 17'd3},   // R6
    {4'd6, 3'd3, 16'd4, 8'd2,  1'b0, 1'b1, 17'd2},   // R6
    {4'd6, 3'd3, 16'd1, 8'd3,  1'b1, 1'b0, 17'd0},   // R6
    {4'd7, 3'd4, 16'd3, 8'd2,  1'b0, 1'b1, 17'd1},   // R7
    {4'd7, 3'd4, 16'd3, 8'd3,  1'b1, 1'b1, 17'd1},   // R7
    {4'd7, 3'd5, 16'd3, 8'd4,  1'b0, 1'b0, 17'd0},   // R7
    {4'd2, 3'd0, 16'd0, 8'd3,  1'b0, 1'b1, 17'd65533} // R2
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic load(input int ch, input logic [2:0] m, input logic [15:0] c, input logic t);
    @(negedge clk);
    ld_en = '0;
    ld_en[ch] = 1'b1;
    ld_mode[3*ch +: 3] = m;
    ld_count[CW*ch +: CW] = c;
    tick_en = t;
    @(negedge clk);
    ld_en = '0;
    tick_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset defaults
    chk("R1 out0", 32'(ch_out[0]), 32'd1);
    chk("R1 out2", 32'(ch_out[2]), 32'd1);
    chk("R1 valid0", 32'(nxt_valid[0]), 32'd1);
    chk("R1 delay0", 32'(nxt_delay[0 +: DW]), 32'd32768);
    chk("R1 gates", 32'(gate_q), 32'b011);

    // R11: gate write on channel 2 only
    gate_wr = 3'b100; gate_val = 3'b100;
    @(negedge clk);
    gate_wr = '0; gate_val = '0;
    chk("R11 gate write", 32'(gate_q), 32'b111);

    for (int i = 0; i < NV; i++) begin
      logic [49:0] v;
      v = VEC[i];
      load(0, v[45:43], v[42:27], 1'b0);
      ticks(int'(v[26:19]));
      chk($sformatf("R%0d out vec%0d", v[49:46], i), 32'(ch_out[0]), 32'(v[18]));
      chk($sformatf("R%0d valid vec%0d", v[49:46], i), 32'(nxt_valid[0]), 32'(v[17]));
      chk($sformatf("R%0d delay vec%0d", v[49:46], i), 32'(nxt_delay[0 +: DW]), 32'(v[16:0]));
    end

    // R9: tick coincident with load is discarded
    load(0, 3'd0, 16'd5, 1'b1);
    chk("R9 load beats tick", 32'(nxt_delay[0 +: DW]), 32'd5);
    ticks(1);
    chk("R9 first tick after load", 32'(nxt_delay[0 +: DW]), 32'd4);

    // R11: channels advance independently of other loads
    load(1, 3'd0, 16'd10, 1'b0);
    ticks(3);
    load(0, 3'd0, 16'd5, 1'b0);
    ticks(2);
    chk("R11 ch1 untouched by ch0 load", 32'(nxt_delay[DW +: DW]), 32'd5);
    chk("R11 ch0 own count", 32'(nxt_delay[0 +: DW]), 32'd3);
    chk("R11 gates kept", 32'(gate_q), 32'b111);

    finish_run();
  end

endmodule